// File: doc/BRIEF.md
# Four-Lane Alignment-Column Deskew

This block sits behind four receive lanes that have already been brought into one shared clock domain. Each lane hands over one 10-bit code group per clock. Every lane carries a skew that is unknown and may wander slowly. The transmitter sends an alignment column at regular intervals. In that column all four lanes carry the same special marker character. The block watches each lane for that marker. It holds back the early lanes in per-lane delay lines until the latest lane's marker shows up, and then emits 40-bit columns in which all four code groups come from the same transmitted column.

Alignment is claimed only after two alignment columns in a row produce identical per-lane delays. After that the block checks every further alignment column. When the spread between lanes changes, the new delays are applied starting with that alignment column itself, and lock is kept. When a marker goes missing on one lane within the search window, lock is dropped and the hunt starts over. Decoding, clock recovery and crossing clock domains happen elsewhere.

Top module: `col_deskew`

## Requirements
- R1: While reset is asserted, `col_data_o` is zero and `col_valid_o`, `col_marker_o` and `locked_o` are low. All three flags stay low until lock is reached.
- R2: A code group is taken as a marker only when all 10 bits equal 0011110011 or 1100001100 (hex 0F3 or 30C). Either value is accepted on any lane, and any other value is not a marker, including the bit-rotated copy 0111100110 (hex 1E6).
- R3: `col_valid_o` and `locked_o` first go high together with the output of the second of two consecutive alignment columns that yield the same per-lane delays. Seeing the first such column alone never raises them.
- R4: Lane i uses bits [10i+9:10i] of both `lane_data_i` and `col_data_o`. Every column output while `col_valid_o` is high holds, on all lanes, the code groups of one and the same transmitted column.
- R5: Markers whose arrivals all fall within 2*MAX_SKEW consecutive cycles (16 cycles by default, so a spread of up to 15 cycles) are aligned. Each lane is delayed by the latest arrival time minus its own arrival time.
- R6: When the first marker of a column is seen on some lane and not every lane shows its marker within the 16-cycle window, lock is lost. `col_valid_o` and `locked_o` are low on the output that follows the last cycle of the window.
- R7: While locked, an alignment column that yields different delays keeps `col_valid_o` and `locked_o` high without a gap. The new delays take effect starting with that alignment column, which comes out whole and aligned.
- R8: `col_marker_o` is high exactly on valid output columns that were recognised as complete alignment columns, and low on all other columns.
- R9: An alignment column appears on the outputs one clock after the cycle in which the latest lane presented its marker.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common deskew clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lane_data_i | input | 40 | One 10-bit code group per lane, lane 0 in the low bits |
| col_data_o | output | 40 | Aligned column, lane 0 in the low bits |
| col_valid_o | output | 1 | Column is aligned and may be used |
| col_marker_o | output | 1 | Column is an alignment column |
| locked_o | output | 1 | Alignment is established |

## Verification
The bench places the last lane's marker 15 cycles behind the first. A delay line one entry short, or a window one cycle short, would then lose lock or pair code groups from different columns. Bit-rotated copies of the marker are sent first, so a matcher that slides within a group would lock 32 cycles too early. One lane's marker is dropped while locked, and the bench expects valid to fall on exactly the cycle the window closes; a block that never closed its window would stay locked on stale delays. Finally, one lane's skew is moved while locked, and the bench expects valid to stay high with realignment from that marker onward; a block that unlocked on any change, or applied the new delays a column late, would show a gap or a torn column.

// File: rtl/col_deskew_pkg.sv
package col_deskew_pkg;

   // lock progression of the alignment controller
   typedef enum logic [1:0] {
      LK_HUNT    = 2'd0,
      LK_CONFIRM = 2'd1,
      LK_LOCKED  = 2'd2
   } lk_state_t;

   // the marker in both running disparities
   localparam logic [9:0] DEF_MARK_A = 10'b0011110011;
   localparam logic [9:0] DEF_MARK_B = 10'b1100001100;

endpackage

// File: rtl/col_lane_delay.sv
module col_lane_delay #(
   parameter int GRP_W = 10,
   parameter int DEPTH = 16,
   localparam int SW   = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [GRP_W-1:0] din,
   input  logic [SW-1:0]    sel,
   output logic [GRP_W-1:0] dout
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("col_lane_delay: DEPTH must be at least 2");
   end

   // tap j holds the code group that arrived j cycles ago
   logic [GRP_W-1:0] taps [DEPTH];

   assign taps[0] = din;

   if (DEPTH > 1) begin : g_line
      logic [GRP_W-1:0] line_q [DEPTH-1];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int j = 0; j < DEPTH-1; j++) line_q[j] <= '0;
         end else begin
            line_q[0] <= din;
            for (int j = 1; j < DEPTH-1; j++) line_q[j] <= line_q[j-1];
         end
      end

      for (genvar j = 1; j < DEPTH; j++) begin : g_tap
         assign taps[j] = line_q[j-1];
      end
   end

   assign dout = taps[sel];

endmodule

// File: rtl/col_marker_track.sv
module col_marker_track #(
   parameter int               LANES  = 4,
   parameter int               GRP_W  = 10,
   parameter int               WIN    = 16,
   parameter logic [GRP_W-1:0] MARK_A = GRP_W'(10'b0011110011),
   parameter logic [GRP_W-1:0] MARK_B = GRP_W'(10'b1100001100),
   localparam int              DW     = $clog2(WIN)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [LANES*GRP_W-1:0] lanes_i,
   output logic                   done_o,
   output logic                   fail_o,
   output logic [LANES*DW-1:0]    dly_o
);

   localparam logic [DW-1:0] LAST = DW'(WIN-1);

   logic [LANES-1:0] hit, seen_q, fresh, seen_all;
   logic             active_q, busy;
   logic [DW-1:0]    cnt_q, cnt_now;
   logic [DW-1:0]    arr_q   [LANES];
   logic [DW-1:0]    arr_eff [LANES];

   // whole-group comparison, no slipping inside a group
   for (genvar i = 0; i < LANES; i++) begin : g_match
      assign hit[i] = (lanes_i[i*GRP_W +: GRP_W] == MARK_A) ||
                      (lanes_i[i*GRP_W +: GRP_W] == MARK_B);
   end

   always_comb begin
      cnt_now  = active_q ? (cnt_q + DW'(1)) : '0;
      fresh    = active_q ? (hit & ~seen_q) : hit;
      seen_all = (active_q ? seen_q : '0) | fresh;
      busy     = active_q | (|hit);
      done_o   = busy & (&seen_all);
      fail_o   = active_q & ~(&seen_all) & (cnt_now == LAST);
   end

   // delay per lane = latest arrival minus own arrival
   for (genvar i = 0; i < LANES; i++) begin : g_dly
      assign arr_eff[i]         = fresh[i] ? cnt_now : arr_q[i];
      assign dly_o[i*DW +: DW]  = cnt_now - arr_eff[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         cnt_q    <= '0;
         seen_q   <= '0;
         for (int i = 0; i < LANES; i++) arr_q[i] <= '0;
      end else if (done_o || fail_o) begin
         active_q <= 1'b0;
         cnt_q    <= '0;
         seen_q   <= '0;
      end else if (busy) begin
         active_q <= 1'b1;
         cnt_q    <= cnt_now;
         seen_q   <= seen_all;
         for (int i = 0; i < LANES; i++) begin
            if (fresh[i]) arr_q[i] <= cnt_now;
         end
      end
   end

   // an open window never runs past its final cycle
   assert_window_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      active_q |-> (cnt_q < LAST));

   // a failed window is closed on the next cycle
   assert_window_closes_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fail_o |=> !active_q);

endmodule

// File: rtl/col_lock_ctrl.sv
module col_lock_ctrl
   import col_deskew_pkg::*;
#(
   parameter int LANES = 4,
   parameter int DW    = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                done_i,
   input  logic                fail_i,
   input  logic [LANES*DW-1:0] dly_i,
   output logic [LANES*DW-1:0] sel_o,
   output logic                lock_nxt_o,
   output logic                locked_o
);

   lk_state_t           st_q, st_d;
   logic [LANES*DW-1:0] cur_q;

   always_comb begin
      st_d = st_q;
      if (fail_i) begin
         st_d = LK_HUNT;
      end else if (done_i) begin
         unique case (st_q)
            LK_HUNT:    st_d = LK_CONFIRM;
            LK_CONFIRM: st_d = (dly_i == cur_q) ? LK_LOCKED : LK_CONFIRM;
            LK_LOCKED:  st_d = LK_LOCKED;
            default:    st_d = LK_HUNT;
         endcase
      end
   end

   // new delays apply from the alignment column itself
   assign sel_o      = done_i ? dly_i : cur_q;
   assign lock_nxt_o = (st_d == LK_LOCKED);
   assign locked_o   = (st_q == LK_LOCKED);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= LK_HUNT;
         cur_q <= '0;
      end else begin
         st_q <= st_d;
         if (done_i) cur_q <= dly_i;
      end
   end

   assert_lock_after_marker_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_q == LK_LOCKED) |-> $past(done_i));

   assert_lock_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fail_i |=> !locked_o);

   assert_track_drift_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (locked_o && done_i) |=> locked_o);

endmodule

// File: rtl/col_deskew.sv
module col_deskew
   import col_deskew_pkg::*;
#(
   parameter int               LANES    = 4,
   parameter int               GRP_W    = 10,
   parameter int               MAX_SKEW = 8,
   parameter logic [GRP_W-1:0] MARK_A   = GRP_W'(DEF_MARK_A),
   parameter logic [GRP_W-1:0] MARK_B   = GRP_W'(DEF_MARK_B)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [LANES*GRP_W-1:0] lane_data_i,
   output logic [LANES*GRP_W-1:0] col_data_o,
   output logic                   col_valid_o,
   output logic                   col_marker_o,
   output logic                   locked_o
);

   localparam int WIN = 2 * MAX_SKEW;
   localparam int DW  = $clog2(WIN);

   if (LANES < 2) begin : g_bad_lanes
      $error("col_deskew: LANES must be at least 2");
   end
   if (MAX_SKEW < 1) begin : g_bad_skew
      $error("col_deskew: MAX_SKEW must be at least 1");
   end
   if (MARK_A == MARK_B) begin : g_bad_mark
      $error("col_deskew: the two marker codes must differ");
   end

   logic                   done, fail, lock_nxt;
   logic [LANES*DW-1:0]    dly, sel;
   logic [LANES*GRP_W-1:0] col_nxt;

   col_marker_track #(
      .LANES (LANES),
      .GRP_W (GRP_W),
      .WIN   (WIN),
      .MARK_A(MARK_A),
      .MARK_B(MARK_B)
   ) u_track (
      .clk    (clk),
      .rst_n  (rst_n),
      .lanes_i(lane_data_i),
      .done_o (done),
      .fail_o (fail),
      .dly_o  (dly)
   );

   col_lock_ctrl #(
      .LANES(LANES),
      .DW   (DW)
   ) u_lock (
      .clk       (clk),
      .rst_n     (rst_n),
      .done_i    (done),
      .fail_i    (fail),
      .dly_i     (dly),
      .sel_o     (sel),
      .lock_nxt_o(lock_nxt),
      .locked_o  (locked_o)
   );

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      col_lane_delay #(
         .GRP_W(GRP_W),
         .DEPTH(WIN)
      ) u_dly (
         .clk  (clk),
         .rst_n(rst_n),
         .din  (lane_data_i[i*GRP_W +: GRP_W]),
         .sel  (sel[i*DW +: DW]),
         .dout (col_nxt[i*GRP_W +: GRP_W])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col_data_o   <= '0;
         col_valid_o  <= 1'b0;
         col_marker_o <= 1'b0;
      end else begin
         col_data_o   <= col_nxt;
         col_valid_o  <= lock_nxt;
         col_marker_o <= done & lock_nxt;
      end
   end

   assert_marker_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
      col_marker_o |-> col_valid_o);

   assert_marker_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && lock_nxt) |=> col_marker_o);

endmodule

// File: tb/sim_col_deskew.sv
module sim_col_deskew;

   localparam int NL = 4;
   localparam int GW = 10;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NL*GW-1:0] lanes = '0;
   logic [NL*GW-1:0] col_data_o;
   logic            col_valid_o, col_marker_o, locked_o;

   int sk [NL];
   int n;
   int fake_lim;
   int drop_k;
   int drop_lane;
   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   col_deskew u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .lane_data_i (lanes),
      .col_data_o  (col_data_o),
      .col_valid_o (col_valid_o),
      .col_marker_o(col_marker_o),
      .locked_o    (locked_o)
   );

   // transmitted column k on lane i
   function automatic logic [GW-1:0] gen(int k, int i);
      logic [GW-1:0] v;
      if (k < 0) return '0;
      if (k % 16 == 0) begin
         if (k < fake_lim) return 10'h1E6;
         if (k == drop_k && i == drop_lane) return 10'h155;
         return (((k / 16) + i) % 2 == 0) ? 10'h0F3 : 10'h30C;
      end
      v = 10'((i % 4) * 256 + (k % 256));
      if (v == 10'h0F3 || v == 10'h30C || v == 10'h1E6) v = v ^ 10'h001;
      return v;
   endfunction

   function automatic int max_skew();
      int m = 0;
      for (int i = 0; i < NL; i++) if (sk[i] > m) m = sk[i];
      return m;
   endfunction

   task automatic drive();
      for (int i = 0; i < NL; i++) lanes[i*GW +: GW] = gen(n - sk[i], i);
   endtask

   task automatic check(bit ok, string req, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s at n=%0d: actual=%0h expected=%0h", req, what, n, act, exp);
      end
   endtask

   // ev: 0 expect invalid, 1 expect valid, 2 do not check flags
   task automatic tick(int ev, bit cd, string req);
      int k;
      @(negedge clk);
      if (ev != 2) begin
         check(col_valid_o == ev[0], req, "valid", longint'(col_valid_o), longint'(ev));
         check(locked_o == ev[0], req, "locked", longint'(locked_o), longint'(ev));
      end
      if (ev == 1 && cd) begin
         k = n - max_skew();
         for (int i = 0; i < NL; i++)
            check(col_data_o[i*GW +: GW] == gen(k, i), "R4", "lane data",
                  longint'(col_data_o[i*GW +: GW]), longint'(gen(k, i)));
         check(col_marker_o == (k % 16 == 0 && k >= fake_lim && k != drop_k), "R8",
               "marker", longint'(col_marker_o),
               longint'(k % 16 == 0 && k >= fake_lim && k != drop_k));
      end
      n++;
      drive();
   endtask

   task automatic restart(int s0, int s1, int s2, int s3, int fl, int dk, int dl);
      @(negedge clk);
      rst_n = 1'b0;
      lanes = '0;
      sk[0] = s0; sk[1] = s1; sk[2] = s2; sk[3] = s3;
      fake_lim = fl; drop_k = dk; drop_lane = dl;
      n = 0;
      repeat (2) @(negedge clk);
      check(col_data_o == '0, "R1", "reset data", longint'(col_data_o), 0);
      check(!col_valid_o && !col_marker_o && !locked_o, "R1", "reset flags",
            longint'({col_valid_o, col_marker_o, locked_o}), 0);
      rst_n = 1'b1;
      drive();
   endtask

   // spread of 15 cycles; lock on the second marker column
   task automatic test_basic();
      restart(0, 5, 15, 9, 0, -1, 0);
      while (n < 80) tick((n >= 31) ? 1 : 0, 1'b1, "R3 R5 R9");
   endtask

   // rotated copies must not count as markers
   task automatic test_patterns();
      restart(3, 3, 3, 3, 32, -1, 0);
      while (n < 70) tick((n >= 51) ? 1 : 0, 1'b1, "R2");
   endtask

   // lane 2 misses the marker of column 48 while locked
   task automatic test_loss();
      restart(0, 2, 4, 6, 0, 48, 2);
      while (n < 110) begin
         if (n < 22)      tick(0, 1'b1, "R6");
         else if (n < 63) tick(1, 1'b1, "R6");
         else if (n < 86) tick(0, 1'b1, "R6");
         else             tick(1, 1'b1, "R6");
      end
   endtask

   // lane 1 drifts from 4 to 7 cycles while locked
   task automatic test_drift();
      restart(2, 4, 6, 8, 0, -1, 0);
      while (n < 100) begin
         tick((n >= 24) ? 1 : 0, (n <= 40 || n >= 56), "R7");
         if (n == 40) sk[1] = 7;
      end
   endtask

   initial begin
      test_basic();
      test_patterns();
      test_loss();
      test_drift();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 8);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=expired expected=complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule